// File: doc/BRIEF.md
# Boot-Time Remote Reconfiguration Sequencer

This controller runs once after every power-up or reset of the device. It keeps its own logic in reset until the clock source reports lock and the device reports that initialization has finished. It then waits a programmable settling interval, because the remote-update register space returns nothing useful for a few hundred microseconds after user mode begins. Only after that wait does it touch a generic remote-update register port, which has a read strobe, a write strobe, a parameter select, a write word, a busy flag and a read word.

The first access reads the address of the image that is running now. When that address is the base image, the controller reads the trigger-condition word. A word of all zeros marks a clean power-up. In that case the controller writes the application start address and the watchdog timeout, enables the watchdog, and commands the reconfiguration. When the running image is the application, the controller pulses a watchdog kick at a fixed period instead. A read that returns all ones means the register space is not ready. The controller never acts on such a value: it restarts the settling wait and retries a bounded number of times, and after that it parks in a sticky error state.

The current state and the done and error flags are exposed so that the order of the sequence can be observed from outside.

Top module: `boot_seq`

## Requirements
- R1: While `clk_locked` and `init_done` are not both high, the sequencer sits in state HOLD (`seq_state` = 0) and issues no strobe. Internal run is granted after the third consecutive rising edge with both inputs high, and the sequencer enters SETTLE (1) at the following edge. Losing either input returns the sequencer to HOLD two edges later and clears the error state.
- R2: The sequencer stays in SETTLE for exactly SETTLE_CYC cycles (default 3000, which is 300 µs at 10 MHz) before the first strobe. It then moves to RD_BOOT (2).
- R3: `ru_rd` and `ru_wr` are single-cycle pulses, never both high, and are raised only in a cycle where `ru_busy` is low. After each strobe the sequencer waits in WAIT (10) until busy has been seen high and then low again.
- R4: The first access after every settling wait is a read with parameter select 0, the running boot address. The only other read uses select 1.
- R5: Read data is taken from `ru_rdata` in the first cycle in which `ru_busy` is low after it was high, and not from any later cycle.
- R6: A boot address equal to BASE_ADDR (default 0x0001_0000) leads to EV_BOOT (3), then RD_TRIG (4), a read of select 1, and EV_TRIG (5). Any other boot address that is not all ones issues no trigger read.
- R7: A trigger word of zero produces exactly four writes, in this order: select 2 with APP_ADDR (default 0x00C0_0000), select 3 with WD_TIMEOUT (default 0x138), select 4 with 1, and select 7 with 1. The states used are WR_APP (6), WR_WDV (7), WR_WDE (8) and WR_CFG (9). The sequencer then rests in DONE (12) with `seq_done` high.
- R8: A trigger word that is neither zero nor all ones leads straight to DONE (12) with no write.
- R9: A boot address other than the base address leads to KICK (11), with `seq_done` high. In KICK, `wdog_kick` pulses for one cycle in every KICK_CYC cycles (default 32000), and the first pulse comes in the KICK_CYC-th cycle spent in KICK.
- R10: An all-ones read value restarts SETTLE and the read sequence. Up to RETRY_MAX such restarts are allowed. The next all-ones value moves the sequencer to ERR (13), where `seq_err` is high and it issues no further strobe for as long as run is held.
- R11: Outside a strobe cycle, `ru_param` and `ru_wdata` are zero. `ru_wdata` is also zero during a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Remote-update clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_locked | input | 1 | Clock source reports lock |
| init_done | input | 1 | Device reports initialization complete |
| ru_busy | input | 1 | Register port is executing a command |
| ru_rdata | input | DATA_W | Read word from the register port |
| ru_rd | output | 1 | Read strobe |
| ru_wr | output | 1 | Write strobe |
| ru_param | output | 3 | Parameter select for the strobe |
| ru_wdata | output | DATA_W | Write word |
| wdog_kick | output | 1 | Watchdog reset pulse |
| seq_state | output | 4 | Current sequencer state code |
| seq_done | output | 1 | Sequence finished (DONE or KICK) |
| seq_err | output | 1 | Sticky retry-exhausted error |

## Verification
On every cycle the bound checker watches these rules:
- strobes never overlap busy and never last two cycles;
- run is granted only after three consecutive edges with lock and init-done both high, and drops one edge after either input falls;
- SETTLE lasts exactly its programmed length;
- kicks come exactly one period apart;
- the error state holds while run is held;
- the write selects stay within the legal set.

Other behaviour shows only in the bench scenarios and its cycle-exact reference model: the order and content of the write sequence, the choice between the base branch and the application branch, read data being taken in the first cycle of busy low and not later, and the exact number of retries before the error.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  localparam int PSEL_W = 3;

  typedef enum logic [3:0] {
    ST_HOLD    = 4'd0,
    ST_SETTLE  = 4'd1,
    ST_RD_BOOT = 4'd2,
    ST_EV_BOOT = 4'd3,
    ST_RD_TRIG = 4'd4,
    ST_EV_TRIG = 4'd5,
    ST_WR_APP  = 4'd6,
    ST_WR_WDV  = 4'd7,
    ST_WR_WDE  = 4'd8,
    ST_WR_CFG  = 4'd9,
    ST_WAIT    = 4'd10,
    ST_KICK    = 4'd11,
    ST_DONE    = 4'd12,
    ST_ERR     = 4'd13
  } seq_st_e;

  // parameter select codes on the register port
  localparam logic [PSEL_W-1:0] PSEL_BOOT = 3'd0;
  localparam logic [PSEL_W-1:0] PSEL_TRIG = 3'd1;
  localparam logic [PSEL_W-1:0] PSEL_APP  = 3'd2;
  localparam logic [PSEL_W-1:0] PSEL_WDV  = 3'd3;
  localparam logic [PSEL_W-1:0] PSEL_WDE  = 3'd4;
  localparam logic [PSEL_W-1:0] PSEL_CFG  = 3'd7;

endpackage

// File: rtl/boot_rst_gate.sv
// Grants run after HOLD_CYC consecutive edges with both status inputs high.
module boot_rst_gate #(
  parameter int HOLD_CYC = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lock_i,
  input  logic init_i,
  output logic run_o
);

  logic [HOLD_CYC-1:0] sr_q;
  logic                both_ok;

  assign both_ok = lock_i && init_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr_q <= '0;
    end else if (!both_ok) begin
      sr_q <= '0;
    end else begin
      sr_q <= (sr_q << 1) | HOLD_CYC'(1);
    end
  end

  assign run_o = sr_q[HOLD_CYC-1];

endmodule

// File: rtl/boot_cnt.sv
// Wrapping interval counter; hit marks the last cycle of each LIMIT-cycle window.
module boot_cnt #(
  parameter int LIMIT = 3000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  output logic hit
);

  localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;

  logic [CW-1:0] cnt_q;

  assign hit = (cnt_q == CW'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (en) begin
      cnt_q <= hit ? '0 : cnt_q + 1'b1;
    end
  end

endmodule

// File: rtl/boot_seq.sv
module boot_seq
  import boot_seq_pkg::*;
#(
  parameter int                DATA_W     = 32,
  parameter logic [DATA_W-1:0] BASE_ADDR  = 32'h0001_0000,
  parameter logic [DATA_W-1:0] APP_ADDR   = 32'h00C0_0000,
  parameter logic [DATA_W-1:0] WD_TIMEOUT = 32'h0000_0138,
  parameter int                SETTLE_CYC = 3000,
  parameter int                KICK_CYC   = 32000,
  parameter int                HOLD_CYC   = 3,
  parameter int                RETRY_MAX  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clk_locked,
  input  logic              init_done,
  input  logic              ru_busy,
  input  logic [DATA_W-1:0] ru_rdata,
  output logic              ru_rd,
  output logic              ru_wr,
  output logic [PSEL_W-1:0] ru_param,
  output logic [DATA_W-1:0] ru_wdata,
  output logic              wdog_kick,
  output logic [3:0]        seq_state,
  output logic              seq_done,
  output logic              seq_err
);

  localparam int RTW = (RETRY_MAX > 0) ? $clog2(RETRY_MAX + 1) : 1;

  seq_st_e           state_q, state_d;
  seq_st_e           ret_q, ret_d, after_cmd;
  logic              seen_q, seen_d;
  logic [RTW-1:0]    retry_q, retry_d;
  logic [DATA_W-1:0] rdata_q;
  logic              cap_en;
  logic              run;
  logic              settle_hit, kick_hit;
  logic              cmd_rd, cmd_wr;
  logic [PSEL_W-1:0] cmd_psel;
  logic [DATA_W-1:0] cmd_data;
  logic              rd_all1;
  logic              retry_out;

  boot_rst_gate #(.HOLD_CYC(HOLD_CYC)) gate_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .lock_i (clk_locked),
    .init_i (init_done),
    .run_o  (run)
  );

  boot_cnt #(.LIMIT(SETTLE_CYC)) settle_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q != ST_SETTLE),
    .en    (state_q == ST_SETTLE),
    .hit   (settle_hit)
  );

  boot_cnt #(.LIMIT(KICK_CYC)) kick_cnt_i (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (state_q != ST_KICK),
    .en    (state_q == ST_KICK),
    .hit   (kick_hit)
  );

  assign rd_all1   = &rdata_q;
  assign retry_out = (retry_q == RTW'(RETRY_MAX));

  // next-state logic
  always_comb begin
    state_d   = state_q;
    ret_d     = ret_q;
    seen_d    = seen_q;
    retry_d   = retry_q;
    cap_en    = 1'b0;
    cmd_rd    = 1'b0;
    cmd_wr    = 1'b0;
    cmd_psel  = PSEL_BOOT;
    cmd_data  = '0;
    after_cmd = ST_HOLD;

    unique case (state_q)
      ST_HOLD:   state_d = ST_SETTLE;
      ST_SETTLE: if (settle_hit) state_d = ST_RD_BOOT;
      ST_RD_BOOT: begin
        cmd_rd = 1'b1; cmd_psel = PSEL_BOOT; after_cmd = ST_EV_BOOT;
      end
      ST_RD_TRIG: begin
        cmd_rd = 1'b1; cmd_psel = PSEL_TRIG; after_cmd = ST_EV_TRIG;
      end
      ST_WR_APP: begin
        cmd_wr = 1'b1; cmd_psel = PSEL_APP; cmd_data = APP_ADDR; after_cmd = ST_WR_WDV;
      end
      ST_WR_WDV: begin
        cmd_wr = 1'b1; cmd_psel = PSEL_WDV; cmd_data = WD_TIMEOUT; after_cmd = ST_WR_WDE;
      end
      ST_WR_WDE: begin
        cmd_wr = 1'b1; cmd_psel = PSEL_WDE; cmd_data = DATA_W'(1); after_cmd = ST_WR_CFG;
      end
      ST_WR_CFG: begin
        cmd_wr = 1'b1; cmd_psel = PSEL_CFG; cmd_data = DATA_W'(1); after_cmd = ST_DONE;
      end
      ST_WAIT: begin
        if (ru_busy) begin
          seen_d = 1'b1;
        end else if (seen_q) begin
          state_d = ret_q;
          cap_en  = 1'b1;
        end
      end
      ST_EV_BOOT, ST_EV_TRIG: begin
        if (rd_all1) begin
          if (retry_out) begin
            state_d = ST_ERR;
          end else begin
            retry_d = retry_q + 1'b1;
            state_d = ST_SETTLE;
          end
        end else if (state_q == ST_EV_BOOT) begin
          state_d = (rdata_q == BASE_ADDR) ? ST_RD_TRIG : ST_KICK;
        end else begin
          state_d = (rdata_q == '0) ? ST_WR_APP : ST_DONE;
        end
      end
      default: state_d = state_q;
    endcase

    if ((cmd_rd || cmd_wr) && !ru_busy) begin
      state_d = ST_WAIT;
      ret_d   = after_cmd;
      seen_d  = 1'b0;
    end
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_HOLD;
      ret_q   <= ST_HOLD;
      seen_q  <= 1'b0;
      retry_q <= '0;
    end else if (!run) begin
      state_q <= ST_HOLD;
      ret_q   <= ST_HOLD;
      seen_q  <= 1'b0;
      retry_q <= '0;
    end else begin
      state_q <= state_d;
      ret_q   <= ret_d;
      seen_q  <= seen_d;
      retry_q <= retry_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (cap_en) begin
      rdata_q <= ru_rdata;
    end
  end

  assign ru_rd     = cmd_rd && !ru_busy;
  assign ru_wr     = cmd_wr && !ru_busy;
  assign ru_param  = (ru_rd || ru_wr) ? cmd_psel : '0;
  assign ru_wdata  = ru_wr ? cmd_data : '0;
  assign wdog_kick = (state_q == ST_KICK) && kick_hit;
  assign seq_state = state_q;
  assign seq_done  = (state_q == ST_KICK) || (state_q == ST_DONE);
  assign seq_err   = (state_q == ST_ERR);

endmodule

// File: rtl/boot_seq_chk.sv
module boot_seq_chk
  import boot_seq_pkg::*;
#(
  parameter int SETTLE_CYC = 3000,
  parameter int KICK_CYC   = 32000,
  parameter int HOLD_CYC   = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run,
  input logic              clk_locked,
  input logic              init_done,
  input logic              ru_busy,
  input logic              ru_rd,
  input logic              ru_wr,
  input logic [PSEL_W-1:0] ru_param,
  input logic [3:0]        state,
  input logic              wdog_kick,
  input logic              seq_err
);

  int both_run;
  int settle_run;
  int kick_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      both_run   <= 0;
      settle_run <= 0;
      kick_run   <= 0;
    end else begin
      if (!(clk_locked && init_done)) both_run <= 0;
      else if (both_run <= HOLD_CYC)  both_run <= both_run + 1;
      settle_run <= (state == ST_SETTLE) ? settle_run + 1 : 0;
      if (state != ST_KICK) kick_run <= 0;
      else if (wdog_kick)   kick_run <= 0;
      else                  kick_run <= kick_run + 1;
    end
  end

  assert_strobe_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ru_rd || ru_wr) |-> !ru_busy);

  assert_strobe_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (ru_rd || ru_wr) |=> !(ru_rd || ru_wr));

  assert_strobe_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(ru_rd && ru_wr));

  assert_run_grant_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (both_run == HOLD_CYC));

  assert_run_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(clk_locked && init_done) |=> !run);

  assert_settle_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETTLE) |-> (settle_run < SETTLE_CYC));

  assert_settle_exit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SETTLE && settle_run == SETTLE_CYC - 1 && run) |=> (state == ST_RD_BOOT));

  assert_read_sel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    ru_rd |-> (ru_param == PSEL_BOOT || ru_param == PSEL_TRIG));

  assert_write_sel_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ru_wr |-> (ru_param == PSEL_APP || ru_param == PSEL_WDV ||
               ru_param == PSEL_WDE || ru_param == PSEL_CFG));

  assert_kick_period_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wdog_kick |-> (kick_run == KICK_CYC - 1));

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_err && run) |=> seq_err);

endmodule

bind boot_seq boot_seq_chk #(
  .SETTLE_CYC (SETTLE_CYC),
  .KICK_CYC   (KICK_CYC),
  .HOLD_CYC   (HOLD_CYC)
) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .run        (run),
  .clk_locked (clk_locked),
  .init_done  (init_done),
  .ru_busy    (ru_busy),
  .ru_rd      (ru_rd),
  .ru_wr      (ru_wr),
  .ru_param   (ru_param),
  .state      (state_q),
  .wdog_kick  (wdog_kick),
  .seq_err    (seq_err)
);

// File: tb/boot_seq_tb_top.sv
module boot_seq_tb_top;

  localparam int SET  = 20;
  localparam int KCY  = 50;
  localparam int RMAX = 2;
  localparam int LAT  = 4;
  localparam logic [31:0] BASE = 32'h0001_0000;
  localparam logic [31:0] APP  = 32'h00C0_0000;
  localparam logic [31:0] WDT  = 32'h0000_0138;
  localparam logic [31:0] ONES = 32'hFFFF_FFFF;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, lk, idn, busy;
  logic [31:0] rdata;
  logic        rd, wr, kick, done, err;
  logic [2:0]  param;
  logic [31:0] wdata;
  logic [3:0]  st;

  boot_seq #(
    .DATA_W(32), .BASE_ADDR(BASE), .APP_ADDR(APP), .WD_TIMEOUT(WDT),
    .SETTLE_CYC(SET), .KICK_CYC(KCY), .HOLD_CYC(3), .RETRY_MAX(RMAX)
  ) dut_i (
    .clk(clk), .rst_n(rst_n), .clk_locked(lk), .init_done(idn),
    .ru_busy(busy), .ru_rdata(rdata), .ru_rd(rd), .ru_wr(wr),
    .ru_param(param), .ru_wdata(wdata), .wdog_kick(kick),
    .seq_state(st), .seq_done(done), .seq_err(err)
  );

  // ---------------- register-port model ----------------
  logic [31:0] boot_val, trig_val, pend;
  int          bad_req;
  int          bad_used;
  int          bcnt;
  int          rd_log[$];
  logic [34:0] wr_log[$];

  always @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      rdata    <= ONES;
      bcnt     <= 0;
      bad_used <= 0;
      pend     <= ONES;
      rd_log.delete();
      wr_log.delete();
    end else if (busy) begin
      if (bcnt == 1) begin
        busy  <= 1'b0;
        rdata <= pend;
      end else begin
        rdata <= ONES;
      end
      bcnt <= bcnt - 1;
    end else begin
      rdata <= ONES;
      if (rd || wr) begin
        busy <= 1'b1;
        bcnt <= LAT;
        if (rd) begin
          rd_log.push_back(int'(param));
          if (bad_used < bad_req) begin
            pend     <= ONES;
            bad_used <= bad_used + 1;
          end else begin
            pend <= (param == 3'd0) ? boot_val : (param == 3'd1) ? trig_val : ONES;
          end
        end else begin
          wr_log.push_back({param, wdata});
          pend <= ONES;
        end
      end
    end
  end

  // ---------------- cycle reference model ----------------
  int          m_st, m_gate, m_sc, m_ret, m_retry, m_kc;
  bit          m_run, m_seen;
  logic [31:0] m_rd;

  task automatic m_bad_read();
    if (m_retry == RMAX) m_st = 13;
    else begin m_retry++; m_st = 1; m_sc = 0; end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_gate = 0; m_sc = 0; m_ret = 0; m_retry = 0; m_kc = 0;
      m_run = 0; m_seen = 0; m_rd = '0;
    end else begin
      if (!m_run) begin
        m_st = 0; m_sc = 0; m_retry = 0; m_seen = 0; m_kc = 0;
      end else begin
        if (m_st == 0) begin m_st = 1; m_sc = 0; end
        else if (m_st == 1) begin
          if (m_sc == SET - 1) m_st = 2; else m_sc++;
        end else if ((m_st == 2 || m_st == 4 || (m_st >= 6 && m_st <= 9)) && !busy) begin
          case (m_st)
            2: m_ret = 3;
            4: m_ret = 5;
            9: m_ret = 12;
            default: m_ret = m_st + 1;
          endcase
          m_st = 10; m_seen = 0;
        end else if (m_st == 10) begin
          if (busy) m_seen = 1;
          else if (m_seen) begin m_st = m_ret; m_rd = rdata; end
        end else if (m_st == 3) begin
          if (m_rd == ONES) m_bad_read();
          else m_st = (m_rd == BASE) ? 4 : 11;
        end else if (m_st == 5) begin
          if (m_rd == ONES) m_bad_read();
          else m_st = (m_rd == 0) ? 6 : 12;
        end else if (m_st == 11) begin
          m_kc = (m_kc == KCY - 1) ? 0 : m_kc + 1;
        end
      end
      if (!(lk && idn)) m_gate = 0;
      else if (m_gate < 3) m_gate++;
      m_run = (m_gate == 3);
    end
  end

  int cyc_chk  = 0;
  int cyc_fail = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      bit          e_rd, e_wr, e_kick, e_done, e_err, bad;
      logic [2:0]  e_par;
      logic [31:0] e_wd;
      e_rd   = (m_st == 2 || m_st == 4) && !busy;
      e_wr   = (m_st >= 6 && m_st <= 9) && !busy;
      e_par  = 3'd0;
      e_wd   = '0;
      if (e_rd) e_par = (m_st == 2) ? 3'd0 : 3'd1;
      if (e_wr) begin
        case (m_st)
          6: begin e_par = 3'd2; e_wd = APP; end
          7: begin e_par = 3'd3; e_wd = WDT; end
          8: begin e_par = 3'd4; e_wd = 32'd1; end
          default: begin e_par = 3'd7; e_wd = 32'd1; end
        endcase
      end
      e_kick = (m_st == 11) && (m_kc == KCY - 1);
      e_done = (m_st == 11) || (m_st == 12);
      e_err  = (m_st == 13);
      bad    = 0;
      cyc_chk++;
      if (st != 4'(m_st)) begin bad = 1; $display("FAIL R1/R2 state actual=%0d expected=%0d", st, m_st); end
      if (rd != e_rd || wr != e_wr) begin bad = 1; $display("FAIL R3 strobes actual=%0b%0b expected=%0b%0b", rd, wr, e_rd, e_wr); end
      if (param != e_par || wdata != e_wd) begin bad = 1; $display("FAIL R11 param/data actual=%0h/%0h expected=%0h/%0h", param, wdata, e_par, e_wd); end
      if (kick != e_kick) begin bad = 1; $display("FAIL R9 kick actual=%0b expected=%0b", kick, e_kick); end
      if (done != e_done) begin bad = 1; $display("FAIL R7 done actual=%0b expected=%0b", done, e_done); end
      if (err != e_err) begin bad = 1; $display("FAIL R10 err actual=%0b expected=%0b", err, e_err); end
      if (bad) cyc_fail++;
    end
  end

  // ---------------- scenario checks ----------------
  int n_chk  = 0;
  int n_fail = 0;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk + cyc_chk, n_fail + cyc_fail);
  endtask

  task automatic wait_end(input int lim);
    int n = 0;
    while (!(done || err) && n < lim) begin @(negedge clk); n++; end
    chk(n < lim, "R7 sequence end reached", n, lim);
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    int kicks, rsz;
    rst_n = 1'b0; lk = 1'b0; idn = 1'b0;
    boot_val = BASE; trig_val = 32'd0; bad_req = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(st == 4'd0 && !rd && !wr && !done && !err && !kick, "R1 reset state", st, 0);

    // R1: only init_done high, then a lock glitch
    idn = 1'b1;
    repeat (5) @(negedge clk);
    chk(st == 4'd0, "R1 held without lock", st, 0);
    lk = 1'b1; repeat (2) @(negedge clk);
    lk = 1'b0; @(negedge clk);
    lk = 1'b1;
    repeat (3) @(negedge clk);
    chk(st == 4'd0, "R1 still HOLD after three edges", st, 0);
    @(negedge clk);
    chk(st == 4'd1, "R1 SETTLE on fourth edge", st, 1);
    repeat (SET - 1) @(negedge clk);
    chk(st == 4'd1 && !rd, "R2 still settling", st, 1);
    @(negedge clk);
    chk(st == 4'd2 && rd && param == 3'd0, "R4 first access reads boot address", {st, rd, param}, {4'd2, 1'b1, 3'd0});
    wait_end(2000);
    chk(st == 4'd12, "R7 rests in DONE", st, 12);
    chk(rd_log.size() == 2 && rd_log[0] == 0 && rd_log[1] == 1, "R6 trigger read follows base", rd_log.size(), 2);
    chk(wr_log.size() == 4, "R7 four writes", wr_log.size(), 4);
    if (wr_log.size() == 4) begin
      chk(wr_log[0] == {3'd2, APP},   "R7 write 1 app address", wr_log[0], {3'd2, APP});
      chk(wr_log[1] == {3'd3, WDT},   "R7 write 2 timeout",     wr_log[1], {3'd3, WDT});
      chk(wr_log[2] == {3'd4, 32'd1}, "R7 write 3 enable",      wr_log[2], {3'd4, 32'd1});
      chk(wr_log[3] == {3'd7, 32'd1}, "R7 write 4 reconfigure", wr_log[3], {3'd7, 32'd1});
    end
    // R5: data shows only in the first busy-low cycle; a late capture reads all ones
    chk(!err, "R5 capture timing", err, 0);

    // R8: nonzero trigger word
    trig_val = 32'h0000_0005;
    do_reset();
    wait_end(2000);
    chk(st == 4'd12 && wr_log.size() == 0, "R8 no writes on nonzero trigger", wr_log.size(), 0);

    // R9: application image running
    boot_val = APP; trig_val = 32'd0;
    do_reset();
    wait_end(2000);
    chk(st == 4'd11, "R9 enters KICK", st, 11);
    chk(rd_log.size() == 1, "R6 no trigger read for application", rd_log.size(), 1);
    kicks = 0;
    for (int i = 0; i < 3 * KCY; i++) begin
      if (kick) kicks++;
      @(negedge clk);
    end
    chk(kicks == 3, "R9 kick count", kicks, 3);

    // R10: two not-ready reads, then success
    boot_val = BASE; bad_req = 2;
    do_reset();
    wait_end(4000);
    chk(st == 4'd12 && rd_log.size() == 4, "R10 retries then completes", rd_log.size(), 4);
    chk(wr_log.size() == 4, "R10 writes after retries", wr_log.size(), 4);

    // R10: exhaust retries
    bad_req = 100;
    do_reset();
    wait_end(4000);
    chk(err && st == 4'd13, "R10 error state", st, 13);
    chk(rd_log.size() == RMAX + 1, "R10 read attempts", rd_log.size(), RMAX + 1);
    rsz = rd_log.size();
    repeat (60) @(negedge clk);
    chk(err && rd_log.size() == rsz, "R10 sticky, no more strobes", rd_log.size(), rsz);

    // R1: losing lock clears the error, then restart
    lk = 1'b0;
    repeat (2) @(negedge clk);
    chk(st == 4'd0 && !err, "R1 lock loss returns to HOLD", st, 0);
    bad_req = 0;
    lk = 1'b1;
    wait_end(4000);
    chk(st == 4'd12 && !err, "R1 restart completes", st, 12);

    summary();
    $finish;
  end

  initial begin
    repeat (30000) @(posedge clk);
    n_fail++;
    $display("FAIL R7 watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

endmodule